// File: doc/BRIEF.md
# Offset-Adjusted Virtual Compare Timer

This block provides a pair of compare timers for one core, both fed by a single free-running 64-bit system count that arrives on an input port. The physical timer compares its limit against the raw count. The virtual timer compares its limit against a derived count, which is the system count minus a programmable 64-bit offset taken modulo 2^64. Each timer drives its own level interrupt output.

Software reaches the block through a single-cycle register port. A write strobe, an address code and write data update a register on the next clock edge. The read data is decoded combinationally from the address. Through this port software can read both counts, read and write the offset, and read and write each timer's limit, its signed down-count view and its control word. When the offset changes, the virtual timer's compare condition is evaluated again against the newly adjusted count.

Top module: `dual_cmp_timer`

## Requirements
- R1: After synchronous reset, the offset, both limits and both control words read 0, and both interrupt outputs are low.
- R2: Address 0 reads the raw system count. Address 1 reads the virtual count, which is the system count minus the offset modulo 2^64.
- R3: Address 2 holds the 64-bit offset. A write takes effect at the next clock edge and reads back exactly.
- R4: Addresses 3 (physical) and 6 (virtual) hold each timer's 64-bit limit. Each reads back exactly what was written.
- R5: The control words are at address 5 (physical) and address 8 (virtual). Bit 0 is enable and bit 1 is mask, and both are writable. Bit 2 is a read-only status. Status is set when enable is 1 and the timer's count is greater than or equal to its limit in an unsigned comparison. Status updates one clock edge after the state that it reflects.
- R6: A timer's interrupt output is high exactly when enable is 1, status is 1 and mask is 0. It follows the same one-edge lag as status, so after a write that sets the mask it stays high for one more cycle and then falls.
- R7: Writing the down-count view, at address 4 (physical) or 7 (virtual), sets the limit to the timer's current count plus the sign-extended low 32 bits of the write data. Reading it returns the low 32 bits of (limit − current count), zero-extended to 64 bits.
- R8: A write to the offset changes the virtual timer's status and interrupt one edge after the write edge, even when the system count does not move.
- R9: The physical timer uses the raw count and the virtual timer uses the adjusted count. Each has its own interrupt output, and both can assert on the same count step.
- R10: Address codes 9 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_count_i | input | 64 | Shared free-running system count |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address code |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Read data for reg_addr_i |
| irq_phys_o | output | 1 | Physical timer level interrupt |
| irq_virt_o | output | 1 | Virtual timer level interrupt |

## Verification
Two kinds of event can meet in the same cycle. The first is a single system-count step that carries both timers past their limits at once. The bench sets the offset equal to the difference between the two limits, so one count value meets both limits together, and it requires both interrupt lines to rise at the same sampling point. The second is a register write landing on a live compare condition, either an offset write or a mask write. For those writes the bench samples the interrupt line once just after the write edge, where it must still show the old level, and once a cycle later, where it must show the new one.

// File: rtl/vtimer_pkg.sv
package vtimer_pkg;

    localparam int CNT_W   = 64;
    localparam int TV_W    = 32;
    localparam int ADDR_W  = 4;
    localparam int NUM_TMR = 2;
    localparam int REGS_PER_TMR = 3;
    localparam int TMR_BASE0    = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_PCNT = 4'd0,
        A_VCNT = 4'd1,
        A_OFFS = 4'd2
    } glob_addr_e;

    // Writable part of a control word: bit1 mask, bit0 enable
    typedef struct packed {
        logic mask;
        logic enable;
    } tmr_ctl_t;

    typedef enum logic [1:0] {
        SUB_CMP  = 2'd0,
        SUB_TVAL = 2'd1,
        SUB_CTL  = 2'd2
    } tmr_sub_e;

    function automatic logic [ADDR_W-1:0] tmr_addr(int idx, tmr_sub_e sub);
        return ADDR_W'(TMR_BASE0 + REGS_PER_TMR * idx + int'(sub));
    endfunction

endpackage

// File: rtl/vt_offset.sv
module vt_offset
    import vtimer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sys_count_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] offset_o,
    output logic [W-1:0] vcount_o
);

    logic [W-1:0] offset_q;

    always_ff @(posedge clk) begin
        if (rst)
            offset_q <= '0;
        else if (wr_i)
            offset_q <= wdata_i;
    end

    assign offset_o = offset_q;
    assign vcount_o = sys_count_i - offset_q;

    AST_OFFSET_LOAD: assert property (@(posedge clk) disable iff (rst)
        $past(wr_i) && !$past(rst) |-> offset_q == $past(wdata_i)); // R3

endmodule

// File: rtl/vt_cmp_unit.sv
module vt_cmp_unit
    import vtimer_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int TW = TV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  count_i,
    input  logic          wr_cmp_i,
    input  logic          wr_tval_i,
    input  logic          wr_ctl_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  cmp_o,
    output logic [TW-1:0] tval_o,
    output logic [2:0]    ctl_o,
    output logic          irq_o
);

    logic [W-1:0] cmp_q;
    tmr_ctl_t     ctl_q;
    logic         status_q;
    logic         irq_q;
    logic [W-1:0] tval_ext;
    logic [W-1:0] remain;
    logic         reached;

    assign tval_ext = {{(W-TW){wdata_i[TW-1]}}, wdata_i[TW-1:0]};
    assign reached  = count_i >= cmp_q;
    assign remain   = cmp_q - count_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q    <= '0;
            ctl_q    <= '0;
            status_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            if (wr_cmp_i)
                cmp_q <= wdata_i;
            else if (wr_tval_i)
                cmp_q <= count_i + tval_ext;
            if (wr_ctl_i)
                ctl_q <= tmr_ctl_t'(wdata_i[1:0]);
            status_q <= ctl_q.enable && reached;
            irq_q    <= ctl_q.enable && reached && !ctl_q.mask;
        end
    end

    assign cmp_o  = cmp_q;
    assign tval_o = remain[TW-1:0];
    assign ctl_o  = {status_q, ctl_q.mask, ctl_q.enable};
    assign irq_o  = irq_q;

    AST_TVAL_LOAD: assert property (@(posedge clk) disable iff (rst)
        $past(wr_tval_i && !wr_cmp_i) && !$past(rst)
        |-> cmp_q == $past(count_i) + $past(tval_ext)); // R7

    AST_STATUS_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        status_q |-> $past(ctl_q.enable)); // R5

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(ctl_q.enable && !ctl_q.mask)); // R6

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> status_q); // R6

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import vtimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  sys_count_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [CNT_W-1:0]  reg_wdata_i,
    output logic [CNT_W-1:0]  reg_rdata_o,
    output logic              irq_phys_o,
    output logic              irq_virt_o
);

    logic [CNT_W-1:0] offset;
    logic [CNT_W-1:0] vcount;
    logic [CNT_W-1:0] tmr_count [NUM_TMR];
    logic [CNT_W-1:0] tmr_cmp   [NUM_TMR];
    logic [TV_W-1:0]  tmr_tval  [NUM_TMR];
    logic [2:0]       tmr_ctl   [NUM_TMR];
    logic [NUM_TMR-1:0] irq_vec;

    vt_offset #(.W(CNT_W)) u_offset (
        .clk        (clk),
        .rst        (rst),
        .sys_count_i(sys_count_i),
        .wr_i       (reg_wr_i && reg_addr_i == A_OFFS),
        .wdata_i    (reg_wdata_i),
        .offset_o   (offset),
        .vcount_o   (vcount)
    );

    // Timer 0 sees the raw count, timer 1 the offset-adjusted count
    assign tmr_count[0] = sys_count_i;
    assign tmr_count[1] = vcount;

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        vt_cmp_unit #(.W(CNT_W), .TW(TV_W)) u_unit (
            .clk      (clk),
            .rst      (rst),
            .count_i  (tmr_count[i]),
            .wr_cmp_i (reg_wr_i && reg_addr_i == tmr_addr(i, SUB_CMP)),
            .wr_tval_i(reg_wr_i && reg_addr_i == tmr_addr(i, SUB_TVAL)),
            .wr_ctl_i (reg_wr_i && reg_addr_i == tmr_addr(i, SUB_CTL)),
            .wdata_i  (reg_wdata_i),
            .cmp_o    (tmr_cmp[i]),
            .tval_o   (tmr_tval[i]),
            .ctl_o    (tmr_ctl[i]),
            .irq_o    (irq_vec[i])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == A_PCNT) reg_rdata_o = sys_count_i;
        if (reg_addr_i == A_VCNT) reg_rdata_o = vcount;
        if (reg_addr_i == A_OFFS) reg_rdata_o = offset;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (reg_addr_i == tmr_addr(i, SUB_CMP))
                reg_rdata_o = tmr_cmp[i];
            if (reg_addr_i == tmr_addr(i, SUB_TVAL))
                reg_rdata_o = {{(CNT_W-TV_W){1'b0}}, tmr_tval[i]};
            if (reg_addr_i == tmr_addr(i, SUB_CTL))
                reg_rdata_o = {{(CNT_W-3){1'b0}}, tmr_ctl[i]};
        end
    end

    assign irq_phys_o = irq_vec[0];
    assign irq_virt_o = irq_vec[1];

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !irq_phys_o && !irq_virt_o); // R1

endmodule

// File: tb/tb_dual_cmp_timer.sv
module tb_dual_cmp_timer;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] sys_count;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [63:0] reg_wdata;
    logic [63:0] reg_rdata;
    logic        irq_phys;
    logic        irq_virt;

    int checks = 0;
    int failures = 0;

    always #(CLK_P/2) clk = ~clk;

    dual_cmp_timer dut (
        .clk        (clk),
        .rst        (rst),
        .sys_count_i(sys_count),
        .reg_wr_i   (reg_wr),
        .reg_addr_i (reg_addr),
        .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .irq_phys_o (irq_phys),
        .irq_virt_o (irq_virt)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [63:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [63:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic settle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_reset();
        logic [63:0] d;
        for (int a = 2; a <= 8; a++) begin
            rd(4'(a), d);
            if (a != 4 && a != 7) chk("R1 reg zero", d, 64'd0);
        end
        chk("R1 irq_phys low", {63'd0, irq_phys}, 64'd0);
        chk("R1 irq_virt low", {63'd0, irq_virt}, 64'd0);
    endtask

    task automatic t_counts();
        logic [63:0] d;
        sys_count = 64'd1000;
        rd(4'd0, d); chk("R2 phys count", d, 64'd1000);
        rd(4'd1, d); chk("R2 virt count no offset", d, 64'd1000);
        wr(4'd2, 64'd300);
        rd(4'd2, d); chk("R3 offset readback", d, 64'd300);
        rd(4'd1, d); chk("R2 virt count", d, 64'd700);
        rd(4'd0, d); chk("R2 phys count unaffected", d, 64'd1000);
        wr(4'd2, 64'd1500);
        rd(4'd1, d); chk("R2 virt count wrap", d, 64'd1000 - 64'd1500);
        wr(4'd2, 64'd0);
    endtask

    task automatic t_compare_rw();
        logic [63:0] d;
        wr(4'd3, 64'hDEAD_BEEF_0123_4567);
        wr(4'd6, 64'h8000_0000_0000_0001);
        rd(4'd3, d); chk("R4 phys limit", d, 64'hDEAD_BEEF_0123_4567);
        rd(4'd6, d); chk("R4 virt limit", d, 64'h8000_0000_0000_0001);
        wr(4'd5, 64'hFFFF_FFFF_FFFF_FFFD);
        settle();
        rd(4'd5, d); chk("R5 ctl writable bits only", d, 64'd1);
    endtask

    task automatic t_phys_fire();
        logic [63:0] d;
        sys_count = 64'd100;
        wr(4'd3, 64'd150);
        wr(4'd5, 64'd1);
        settle();
        rd(4'd5, d); chk("R5 status clear below limit", d, 64'd1);
        sys_count = 64'd149; settle();
        chk("R6 irq low at limit-1", {63'd0, irq_phys}, 64'd0);
        sys_count = 64'd150; settle();
        rd(4'd5, d); chk("R5 status at limit", d, 64'd5);
        chk("R6 irq at limit", {63'd0, irq_phys}, 64'd1);
        chk("R9 virt irq independent", {63'd0, irq_virt}, 64'd0);
        wr(4'd5, 64'd3);
        chk("R6 irq lags mask by one edge", {63'd0, irq_phys}, 64'd1);
        settle();
        chk("R6 irq masked", {63'd0, irq_phys}, 64'd0);
        rd(4'd5, d); chk("R5 status while masked", d, 64'd7);
        wr(4'd5, 64'd1); settle();
        chk("R6 irq unmasked", {63'd0, irq_phys}, 64'd1);
        wr(4'd5, 64'd0); settle();
        chk("R6 irq disabled", {63'd0, irq_phys}, 64'd0);
        rd(4'd5, d); chk("R5 status cleared by disable", d, 64'd0);
    endtask

    task automatic t_tval();
        logic [63:0] d;
        sys_count = 64'd5000;
        wr(4'd4, 64'h0000_0000_FFFF_FFF6);
        rd(4'd3, d); chk("R7 negative tval load", d, 64'd4990);
        rd(4'd4, d); chk("R7 tval read negative", d, 64'h0000_0000_FFFF_FFF6);
        wr(4'd4, 64'hFFFF_FFFF_0000_00C8);
        rd(4'd3, d); chk("R7 positive tval load", d, 64'd5200);
        sys_count = 64'd5100;
        rd(4'd4, d); chk("R7 tval tracks count", d, 64'd100);
        wr(4'd2, 64'd1000);
        wr(4'd7, 64'd50);
        rd(4'd6, d); chk("R7 virt tval uses adjusted count", d, 64'd4150);
    endtask

    task automatic t_offset_reeval();
        logic [63:0] d;
        wr(4'd8, 64'd1); settle();
        chk("R8 virt irq low before", {63'd0, irq_virt}, 64'd0);
        wr(4'd2, 64'd900);
        chk("R8 irq one edge after offset write", {63'd0, irq_virt}, 64'd0);
        settle();
        chk("R8 virt irq after offset", {63'd0, irq_virt}, 64'd1);
        rd(4'd8, d); chk("R8 virt status", d, 64'd5);
        chk("R9 phys irq unaffected", {63'd0, irq_phys}, 64'd0);
        wr(4'd2, 64'd2000); settle();
        chk("R8 virt irq drops", {63'd0, irq_virt}, 64'd0);
    endtask

    task automatic t_same_step();
        wr(4'd2, 64'd500);
        wr(4'd3, 64'd10000);
        wr(4'd6, 64'd9500);
        wr(4'd5, 64'd1);
        wr(4'd8, 64'd1);
        sys_count = 64'd9999; settle();
        chk("R9 phys low before step", {63'd0, irq_phys}, 64'd0);
        chk("R9 virt low before step", {63'd0, irq_virt}, 64'd0);
        sys_count = 64'd10000; settle();
        chk("R9 phys fires on step", {63'd0, irq_phys}, 64'd1);
        chk("R9 virt fires same step", {63'd0, irq_virt}, 64'd1);
    endtask

    task automatic t_unmapped();
        logic [63:0] d;
        for (int a = 9; a <= 15; a++) begin
            rd(4'(a), d);
            chk("R10 unmapped reads zero", d, 64'd0);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; sys_count = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_counts();
        t_compare_rw();
        t_phys_fire();
        t_tval();
        t_offset_reeval();
        t_same_step();
        t_unmapped();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule